// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block joins two data ports, A and B, through two separate banks of storage. One bank carries data from A towards B and the other carries data from B towards A. Each direction has three active-low controls: a chip enable, a latch enable and an output enable. A bank captures its input port only while both its chip enable and its latch enable are low. It keeps its contents once either of them goes high.

The opposite port is driven from the stored word only while that direction's chip enable and output enable are both low. Three-state pins are modelled as a data vector together with a separate drive-enable vector. Each side of the chip can then place its own pad buffers.

The data width is divided into lanes, two 8-bit lanes by default. Every lane has a full, independent set of controls for both directions. Tying the controls of the lanes together makes the block act as one wide transceiver. The storage is modelled in a synchronous way: a transparent bank samples its input port on every clock edge, so the stored value is the last word sampled while the bank was transparent.

Top module: `bidirLatchXcvr`

## Requirements
- R1: While rstN is low, every bit of aDrvEn and bDrvEn is 0. The first clock edge with rstN low clears both storage banks, so aOut and bOut read 0.
- R2: If abCeN[h] and abLeN[h] are both 0 at a clock edge, lane h of bOut (bits h*8+7 down to h*8) equals lane h of aIn sampled at that edge from then on.
- R3: If abLeN[h] is 1 at a clock edge, lane h of bOut keeps its value across that edge. This covers the edge where the latch enable rises, which freezes the last word captured.
- R4: If abCeN[h] is 1 at a clock edge, lane h of bOut keeps its value whatever abLeN[h] and aIn are.
- R5: bDrvEn[h] is 1 exactly when rstN is 1, abCeN[h] is 0 and abOeN[h] is 0, with no clock delay. The value of abLeN[h] has no effect on it.
- R6: The B-to-A direction follows the same rules, using baCeN, baLeN and baOeN, lane h of bIn, lane h of aOut and aDrvEn[h]. Its bank does not depend on the A-to-B bank.
- R7: The controls of one lane have no effect on the stored data or drive enables of the other lane.
- R8: aOut and bOut always show the stored contents, whether or not the matching drive enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aIn | input | 16 | Data sampled from port A |
| bIn | input | 16 | Data sampled from port B |
| abCeN | input | 2 | A-to-B chip enable per lane, active low |
| abLeN | input | 2 | A-to-B latch enable per lane, active low |
| abOeN | input | 2 | A-to-B output enable per lane, active low |
| baCeN | input | 2 | B-to-A chip enable per lane, active low |
| baLeN | input | 2 | B-to-A latch enable per lane, active low |
| baOeN | input | 2 | B-to-A output enable per lane, active low |
| bOut | output | 16 | Data presented to port B from the A-to-B bank |
| bDrvEn | output | 2 | Drive enable for port B, per lane |
| aOut | output | 16 | Data presented to port A from the B-to-A bank |
| aDrvEn | output | 2 | Drive enable for port A, per lane |

## Verification
On every cycle the assertions check, for each lane and each direction, the following: capture while transparent, hold when the latch enable is high, hold when the chip enable is high, the combinational rule for the drive enable, and the absence of drive during reset. Some behaviour cannot be seen from one cycle alone and needs the bench's scenarios. These are the frozen word after a rise of the latch enable, followed by a long run of changing input. They also include the separation between lanes, where one lane loads while the other holds. Last, the two banks must keep separate contents while both directions are active at once.

// File: rtl/bidirLatchXcvr_pkg.sv
package bidirLatchXcvr_pkg;

  // Per-lane strobes passed from the control logic to the datapath
  typedef struct packed {
    logic abLoad;
    logic abDrive;
    logic baLoad;
    logic baDrive;
  } laneStrobe_t;

endpackage

// File: rtl/latchBank.sv
// One storage bank for one lane and one direction
module latchBank #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qOut
);

  logic [WIDTH-1:0] store;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      store <= '0;
    end else if (load) begin
      store <= dIn;
    end
  end

  assign qOut = store;

endmodule

// File: rtl/xcvrCtrl.sv
// Decodes the active-low controls into per-lane strobes
module xcvrCtrl
  import bidirLatchXcvr_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                    rstN,
  input  logic [LANES-1:0]        abCeN,
  input  logic [LANES-1:0]        abLeN,
  input  logic [LANES-1:0]        abOeN,
  input  logic [LANES-1:0]        baCeN,
  input  logic [LANES-1:0]        baLeN,
  input  logic [LANES-1:0]        baOeN,
  output laneStrobe_t [LANES-1:0] strobes
);

  for (genvar h = 0; h < LANES; h++) begin : g_lane
    always_comb begin
      strobes[h].abLoad  = ~abCeN[h] & ~abLeN[h];
      strobes[h].abDrive = rstN & ~abCeN[h] & ~abOeN[h];
      strobes[h].baLoad  = ~baCeN[h] & ~baLeN[h];
      strobes[h].baDrive = rstN & ~baCeN[h] & ~baOeN[h];
    end
  end

endmodule

// File: rtl/xcvrDatapath.sv
// Holds the two storage banks for every lane
module xcvrDatapath
  import bidirLatchXcvr_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int BUS_W = LANES * LANE_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  laneStrobe_t [LANES-1:0] strobes,
  input  logic [BUS_W-1:0]        aIn,
  input  logic [BUS_W-1:0]        bIn,
  output logic [BUS_W-1:0]        bOut,
  output logic [LANES-1:0]        bDrvEn,
  output logic [BUS_W-1:0]        aOut,
  output logic [LANES-1:0]        aDrvEn
);

  for (genvar h = 0; h < LANES; h++) begin : g_lane
    latchBank #(.WIDTH(LANE_W)) abBank_i (
      .clk  (clk),
      .rstN (rstN),
      .load (strobes[h].abLoad),
      .dIn  (aIn[h*LANE_W +: LANE_W]),
      .qOut (bOut[h*LANE_W +: LANE_W])
    );

    latchBank #(.WIDTH(LANE_W)) baBank_i (
      .clk  (clk),
      .rstN (rstN),
      .load (strobes[h].baLoad),
      .dIn  (bIn[h*LANE_W +: LANE_W]),
      .qOut (aOut[h*LANE_W +: LANE_W])
    );

    assign bDrvEn[h] = strobes[h].abDrive;
    assign aDrvEn[h] = strobes[h].baDrive;
  end

endmodule

// File: rtl/bidirLatchXcvr.sv
module bidirLatchXcvr
  import bidirLatchXcvr_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int BUS_W = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [BUS_W-1:0] aIn,
  input  logic [BUS_W-1:0] bIn,
  input  logic [LANES-1:0] abCeN,
  input  logic [LANES-1:0] abLeN,
  input  logic [LANES-1:0] abOeN,
  input  logic [LANES-1:0] baCeN,
  input  logic [LANES-1:0] baLeN,
  input  logic [LANES-1:0] baOeN,
  output logic [BUS_W-1:0] bOut,
  output logic [LANES-1:0] bDrvEn,
  output logic [BUS_W-1:0] aOut,
  output logic [LANES-1:0] aDrvEn
);

  laneStrobe_t [LANES-1:0] strobes;

  xcvrCtrl #(.LANES(LANES)) ctrl_i (
    .rstN    (rstN),
    .abCeN   (abCeN),
    .abLeN   (abLeN),
    .abOeN   (abOeN),
    .baCeN   (baCeN),
    .baLeN   (baLeN),
    .baOeN   (baOeN),
    .strobes (strobes)
  );

  xcvrDatapath #(.LANES(LANES), .LANE_W(LANE_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .aIn     (aIn),
    .bIn     (bIn),
    .bOut    (bOut),
    .bDrvEn  (bDrvEn),
    .aOut    (aOut),
    .aDrvEn  (aDrvEn)
  );

endmodule

// File: rtl/bidirLatchXcvr_checker.sv
module bidirLatchXcvr_checker #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int BUS_W = LANES * LANE_W
) (
  input logic             clk,
  input logic             rstN,
  input logic [BUS_W-1:0] aIn,
  input logic [BUS_W-1:0] bIn,
  input logic [LANES-1:0] abCeN,
  input logic [LANES-1:0] abLeN,
  input logic [LANES-1:0] abOeN,
  input logic [LANES-1:0] baCeN,
  input logic [LANES-1:0] baLeN,
  input logic [LANES-1:0] baOeN,
  input logic [BUS_W-1:0] bOut,
  input logic [LANES-1:0] bDrvEn,
  input logic [BUS_W-1:0] aOut,
  input logic [LANES-1:0] aDrvEn
);

  // R1: no lane drives while reset is held
  always_comb begin
    if (rstN == 1'b0) begin
      p_no_drive_in_reset_r1: assert (bDrvEn == '0 && aDrvEn == '0);
    end
  end

  for (genvar h = 0; h < LANES; h++) begin : g_lane
    p_ab_load_r2: assert property (@(posedge clk) disable iff (!rstN)
      (!abCeN[h] && !abLeN[h]) |=> bOut[h*LANE_W +: LANE_W] == $past(aIn[h*LANE_W +: LANE_W]));

    p_ab_hold_le_r3: assert property (@(posedge clk) disable iff (!rstN)
      abLeN[h] |=> $stable(bOut[h*LANE_W +: LANE_W]));

    p_ab_hold_ce_r4: assert property (@(posedge clk) disable iff (!rstN)
      abCeN[h] |=> $stable(bOut[h*LANE_W +: LANE_W]));

    p_ab_drive_r5: assert property (@(posedge clk) disable iff (!rstN)
      bDrvEn[h] == (!abCeN[h] && !abOeN[h]));

    p_ba_load_r6: assert property (@(posedge clk) disable iff (!rstN)
      (!baCeN[h] && !baLeN[h]) |=> aOut[h*LANE_W +: LANE_W] == $past(bIn[h*LANE_W +: LANE_W]));

    p_ba_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
      (baCeN[h] || baLeN[h]) |=> $stable(aOut[h*LANE_W +: LANE_W]));

    p_ba_drive_r6: assert property (@(posedge clk) disable iff (!rstN)
      aDrvEn[h] == (!baCeN[h] && !baOeN[h]));
  end

endmodule

bind bidirLatchXcvr bidirLatchXcvr_checker #(.LANES(LANES), .LANE_W(LANE_W)) chk_i (.*);

// File: tb/bidirLatchXcvr_tb_top.sv
module bidirLatchXcvr_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int BUS_W  = LANES * LANE_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [BUS_W-1:0] aIn = '0, bIn = '0;
  logic [LANES-1:0] abCeN = '1, abLeN = '1, abOeN = '1;
  logic [LANES-1:0] baCeN = '1, baLeN = '1, baOeN = '1;
  logic [BUS_W-1:0] bOut, aOut;
  logic [LANES-1:0] bDrvEn, aDrvEn;

  int nTests = 0;
  int nFails = 0;
  bit finished = 0;

  logic [LANE_W-1:0] abModel [LANES];
  logic [LANE_W-1:0] baModel [LANES];

  always #(CLK_PERIOD/2) clk = ~clk;

  bidirLatchXcvr #(.LANES(LANES), .LANE_W(LANE_W)) dut_i (
    .clk(clk), .rstN(rstN), .aIn(aIn), .bIn(bIn),
    .abCeN(abCeN), .abLeN(abLeN), .abOeN(abOeN),
    .baCeN(baCeN), .baLeN(baLeN), .baOeN(baOeN),
    .bOut(bOut), .bDrvEn(bDrvEn), .aOut(aOut), .aDrvEn(aDrvEn)
  );

  function automatic logic [LANE_W-1:0] nextStore(logic [LANE_W-1:0] old, logic ceN,
                                                  logic leN, logic [LANE_W-1:0] din);
    return (!ceN && !leN) ? din : old;
  endfunction

  function automatic logic expDrive(logic rst, logic ceN, logic oeN);
    return rst && !ceN && !oeN;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkDrives(string req);
    for (int h = 0; h < LANES; h++) begin
      check(req, 32'(bDrvEn[h]), 32'(expDrive(rstN, abCeN[h], abOeN[h])));
      check(req, 32'(aDrvEn[h]), 32'(expDrive(rstN, baCeN[h], baOeN[h])));
    end
  endtask

  task automatic checkData(string reqAb, string reqBa);
    for (int h = 0; h < LANES; h++) begin
      check(reqAb, 32'(bOut[h*LANE_W +: LANE_W]), 32'(abModel[h]));
      check(reqBa, 32'(aOut[h*LANE_W +: LANE_W]), 32'(baModel[h]));
    end
  endtask

  // Inputs are applied at a falling edge; drives are checked at once and
  // data one rising edge later, at the following falling edge.
  task automatic step(string reqAb, string reqBa, string reqDrv);
    #1;
    checkDrives(reqDrv);
    @(posedge clk);
    for (int h = 0; h < LANES; h++) begin
      abModel[h] = nextStore(abModel[h], abCeN[h], abLeN[h], aIn[h*LANE_W +: LANE_W]);
      baModel[h] = nextStore(baModel[h], baCeN[h], baLeN[h], bIn[h*LANE_W +: LANE_W]);
    end
    @(negedge clk);
    checkData(reqAb, reqBa);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nTests++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234ABCD));
    for (int h = 0; h < LANES; h++) begin
      abModel[h] = '0;
      baModel[h] = '0;
    end

    // R1: reset with all enables low and data present
    abCeN = '0; abOeN = '0; abLeN = '0; baCeN = '0; baOeN = '0; baLeN = '0;
    aIn = 16'hA5C3; bIn = 16'h3C5A;
    repeat (3) @(negedge clk);
    checkDrives("R1");
    checkData("R1", "R1");
    rstN = 1'b1;
    abLeN = '1; baLeN = '1; abOeN = '1; baOeN = '1;
    @(negedge clk);

    // R2: transparent load in both lanes, R8 data visible without drive
    abCeN = '0; abLeN = '0; aIn = 16'h1234;
    step("R2", "R6", "R5");
    check("R8", 32'(bOut), 32'h1234);

    // R3: raise latch enable, freeze, then change input
    abLeN = '1; aIn = 16'hFFFF;
    step("R3", "R6", "R5");
    aIn = 16'h0F0F; abOeN = '0;
    step("R3", "R6", "R5");

    // R4: chip enable high with latch enable low
    abCeN = '1; abLeN = '0; aIn = 16'hBEEF;
    step("R4", "R6", "R5");

    // R7: lane 0 loads, lane 1 held by its own chip enable
    abCeN = 2'b10; abLeN = 2'b00; abOeN = 2'b01; aIn = 16'h7788;
    step("R7", "R6", "R7");
    check("R7", 32'(bOut[15:8]), 32'h12);

    // R6: B-to-A load and hold, A-to-B active at the same time
    abCeN = '0; abLeN = '0; baCeN = '0; baLeN = '0; baOeN = '0; abOeN = '0;
    aIn = 16'h4455; bIn = 16'h99AA;
    step("R2", "R6", "R6");
    baLeN = '1; bIn = 16'h0000;
    step("R2", "R6", "R6");

    // Random traffic
    for (int i = 0; i < 400; i++) begin
      aIn   = 16'($urandom);
      bIn   = 16'($urandom);
      abCeN = 2'($urandom) & 2'($urandom);
      abLeN = 2'($urandom);
      abOeN = 2'($urandom);
      baCeN = 2'($urandom) & 2'($urandom);
      baLeN = 2'($urandom);
      baOeN = 2'($urandom);
      step("R2", "R6", "R5");
    end

    // R1: mid-run reset clears storage and drop drives
    abCeN = '0; abOeN = '0; baCeN = '0; baOeN = '0;
    rstN = 1'b0;
    #1;
    checkDrives("R1");
    @(negedge clk);
    for (int h = 0; h < LANES; h++) begin
      abModel[h] = '0;
      baModel[h] = '0;
    end
    checkData("R1", "R1");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule